// File: doc/BRIEF.md
# Shared-Input Multi-Filter Dot-Product Engine

This block is the arithmetic core of a neural-network layer pipeline. Convolution and fully connected layers go through the same datapath. A convolution window of Cl channels by K×K taps is flattened into one reduction of Cl×K×K multiply-accumulate terms. A fully connected neuron is the same reduction with K=1. Each cycle the upstream feeder presents one vector of `VEC` signed 8-bit activations and, for each of `CU` filter units, one vector of `VEC` signed 8-bit weights. Every unit multiplies the shared activation vector by its own weights lane by lane and reduces the products through a registered adder tree. It then adds the tree result into a 32-bit signed accumulator.

The number of vectors that make up one output is set by `cfg_terms`, which should equal ceil(Cl×K×K / VEC). When the last vector of a group reaches the accumulator, every unit emits its total at the same time, and the accumulator restarts from zero. Each total is arithmetically shifted right by `cfg_shift` and clamped to 8 bits. A small control delay line, as deep as the adder tree, keeps the valid and end-of-group flags aligned with the tree output. Because of this, gaps in the input stream cost nothing but idle cycles.

Top module: `dpe_engine`

## Requirements
- R1: For each unit, each output equals the sum over the `cfg_terms` accepted vectors of the sum over all lanes of (activation × weight). All values are signed two's-complement 8-bit. The sum is arithmetically shifted right by `cfg_shift` and clamped to [-128, 127].
- R2: Activation lane l is `in_data[8l+7:8l]`. Unit u uses weight lane l at `in_wgt[8(u·VEC+l)+7 : 8(u·VEC+l)]`. The result of unit u appears at `out_res[8u+7:8u]`. All units share the same activation vector.
- R3: `out_valid` is high for exactly one cycle for each group of `cfg_terms` accepted vectors. It rises L+2 rising edges after the edge that samples the group's last vector, where L = ceil(log2(VEC)). `out_res` holds its value until the next pulse.
- R4: A cycle with `in_valid` low changes neither the term count nor any accumulator, whatever `in_data` and `in_wgt` carry.
- R5: After an output is emitted, each accumulator restarts from zero, so the next output depends only on the next group's vectors.
- R6: A shifted total above 127 gives 127, and one below -128 gives -128.
- R7: The right shift is arithmetic, rounding toward minus infinity, for any `cfg_shift` from 0 to 31.
- R8: A `cfg_terms` of 0 behaves as 1.
- R9: While reset is applied and after it is released, `out_valid` and `out_res` are 0 until the first result.
- R10: With `cfg_terms` of 1 and `in_valid` held high, one result is produced on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input vector present this cycle |
| in_data | input | VEC·8 | Shared activation vector, lane l at bits 8l+7:8l |
| in_wgt | input | CU·VEC·8 | Weight vectors, unit u lane l at bits 8(u·VEC+l)+7:8(u·VEC+l) |
| cfg_terms | input | CNTW | Vectors per output (0 treated as 1) |
| cfg_shift | input | SHW | Right shift applied to each total before clamping |
| out_valid | output | 1 | One-cycle strobe, results present |
| out_res | output | CU·8 | Clamped results, unit u at bits 8u+7:8u |

## Verification
The bench builds the engine with VEC=3 and CU=2. The odd lane count pads the adder tree to four leaves with a zero leaf and gives a two-level tree, so L=2 and the expected latency is four edges. Two units with independent random weights show that each unit picks its own weight slice while reading the shared activations. Small activation ranges keep the totals exact. Full-scale operands drive both clamp limits. Idle cycles carrying random junk, together with a zero term count, exercise the count and gap rules.

// File: rtl/dpe_pkg.sv
package dpe_pkg;

  localparam int DW = 8;

  typedef struct packed {
    logic vld;
    logic last;
  } dpe_ctl_t;

  function automatic logic signed [DW-1:0] clamp_to_dw(input logic signed [63:0] v);
    logic signed [63:0] hi;
    logic signed [63:0] lo;
    hi = 64'sd127;
    lo = -64'sd128;
    if (v > hi)      return DW'(8'sd127);
    else if (v < lo) return DW'(-8'sd128);
    else             return v[DW-1:0];
  endfunction

endpackage

// File: rtl/dpe_term_ctrl.sv
module dpe_term_ctrl
  import dpe_pkg::*;
#(
  parameter int CNTW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [CNTW-1:0] cfg_terms,
  output dpe_ctl_t        ctl_q
);

  logic [CNTW-1:0] cnt_q;
  logic [CNTW-1:0] cnt_d;
  logic            is_last;
  dpe_ctl_t        ctl_d;

  always_comb begin
    is_last = (({1'b0, cnt_q} + (CNTW+1)'(1)) >= {1'b0, cfg_terms});
    cnt_d   = cnt_q;
    if (in_valid) begin
      cnt_d = is_last ? '0 : cnt_q + CNTW'(1);
    end
    ctl_d.vld  = in_valid;
    ctl_d.last = in_valid & is_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ctl_q <= '0;
    end else begin
      if (in_valid) cnt_q <= cnt_d;
      ctl_q <= ctl_d;
    end
  end

  // R3
  group_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_last) |=> (cnt_q == '0));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(cnt_q));

endmodule

// File: rtl/dpe_delay.sv
module dpe_delay
  import dpe_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  dpe_ctl_t ctl_in,
  output dpe_ctl_t ctl_out
);

  if (DEPTH == 0) begin : g_pass
    assign ctl_out = ctl_in;
  end else begin : g_line
    dpe_ctl_t stg_q [DEPTH];
    dpe_ctl_t stg_d [DEPTH];

    always_comb begin
      stg_d[0] = ctl_in;
      for (int i = 1; i < DEPTH; i++) stg_d[i] = stg_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) stg_q[i] <= '0;
      end else begin
        for (int i = 0; i < DEPTH; i++) stg_q[i] <= stg_d[i];
      end
    end

    assign ctl_out = stg_q[DEPTH-1];
  end

endmodule

// File: rtl/dpe_unit.sv
module dpe_unit
  import dpe_pkg::*;
#(
  parameter int VEC  = 8,
  parameter int ACCW = 32,
  parameter int SHW  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              v_in,
  input  logic [VEC*DW-1:0] d_vec,
  input  logic [VEC*DW-1:0] w_vec,
  input  logic              acc_en,
  input  logic              acc_last,
  input  logic [SHW-1:0]    cfg_shift,
  output logic [DW-1:0]     res_q
);

  localparam int L  = $clog2(VEC);
  localparam int NP = 1 << L;

  logic signed [ACCW-1:0] prod_d [NP];
  logic signed [ACCW-1:0] prod_q [NP];
  logic signed [ACCW-1:0] tree_sum;

  always_comb begin
    for (int l = 0; l < NP; l++) begin
      if (l < VEC) prod_d[l] = $signed(d_vec[l*DW +: DW]) * $signed(w_vec[l*DW +: DW]);
      else         prod_d[l] = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < NP; l++) prod_q[l] <= '0;
    end else if (v_in) begin
      for (int l = 0; l < NP; l++) prod_q[l] <= prod_d[l];
    end
  end

  for (genvar k = 1; k <= L; k++) begin : g_lvl
    localparam int W = NP >> k;
    logic signed [ACCW-1:0] a [2*W];
    logic signed [ACCW-1:0] s [W];
    if (k == 1) begin : g_src
      assign a = prod_q;
    end else begin : g_src
      assign a = g_lvl[k-1].s;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < W; i++) s[i] <= '0;
      end else begin
        for (int i = 0; i < W; i++) s[i] <= a[2*i] + a[2*i+1];
      end
    end
  end

  if (L == 0) begin : g_sum0
    assign tree_sum = prod_q[0];
  end else begin : g_sumn
    assign tree_sum = g_lvl[L].s[0];
  end

  logic signed [ACCW-1:0] acc_q;
  logic signed [ACCW-1:0] acc_d;
  logic signed [ACCW-1:0] total;
  logic signed [ACCW-1:0] shifted;
  logic signed [63:0]     wide;
  logic [DW-1:0]          res_d;

  always_comb begin
    total   = acc_q + tree_sum;
    shifted = total >>> cfg_shift;
    wide    = shifted;
    res_d   = clamp_to_dw(wide);
    acc_d   = acc_last ? '0 : total;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      res_q <= '0;
    end else begin
      if (acc_en) acc_q <= acc_d;
      if (acc_en && acc_last) res_q <= res_d;
    end
  end

  // R5
  acc_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_last) |=> (acc_q == '0));

  // R4
  acc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en |=> $stable(acc_q));

endmodule

// File: rtl/dpe_engine.sv
module dpe_engine
  import dpe_pkg::*;
#(
  parameter int VEC  = 8,
  parameter int CU   = 4,
  parameter int ACCW = 32,
  parameter int CNTW = 16,
  parameter int SHW  = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [VEC*DW-1:0]    in_data,
  input  logic [CU*VEC*DW-1:0] in_wgt,
  input  logic [CNTW-1:0]      cfg_terms,
  input  logic [SHW-1:0]       cfg_shift,
  output logic                 out_valid,
  output logic [CU*DW-1:0]     out_res
);

  localparam int L   = $clog2(VEC);
  localparam int LAT = L + 2;

  logic rst_meta;
  logic rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  dpe_ctl_t ctl0;
  dpe_ctl_t ctl_acc;

  dpe_term_ctrl #(.CNTW(CNTW)) i_term (
    .clk      (clk),
    .rst_n    (rst_q),
    .in_valid (in_valid),
    .cfg_terms(cfg_terms),
    .ctl_q    (ctl0)
  );

  dpe_delay #(.DEPTH(L)) i_delay (
    .clk    (clk),
    .rst_n  (rst_q),
    .ctl_in (ctl0),
    .ctl_out(ctl_acc)
  );

  for (genvar u = 0; u < CU; u++) begin : g_cu
    dpe_unit #(.VEC(VEC), .ACCW(ACCW), .SHW(SHW)) i_unit (
      .clk      (clk),
      .rst_n    (rst_q),
      .v_in     (in_valid),
      .d_vec    (in_data),
      .w_vec    (in_wgt[u*VEC*DW +: VEC*DW]),
      .acc_en   (ctl_acc.vld),
      .acc_last (ctl_acc.last),
      .cfg_shift(cfg_shift),
      .res_q    (out_res[u*DW +: DW])
    );
  end

  logic out_valid_d;

  always_comb out_valid_d = ctl_acc.vld & ctl_acc.last;

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) out_valid <= 1'b0;
    else        out_valid <= out_valid_d;
  end

  // R3
  strobe_latency_chk: assert property (@(posedge clk) disable iff (!rst_q)
    out_valid |-> $past(in_valid, LAT));

endmodule

// File: tb/test_dpe_engine.sv
`timescale 1ns/1ps
module test_dpe_engine;
  localparam int VEC  = 3;
  localparam int CU   = 2;
  localparam int CNTW = 16;
  localparam int SHW  = 5;
  localparam int DW   = 8;
  localparam int LAT  = 4;

  logic                 clk;
  logic                 rst_n;
  logic                 in_valid;
  logic [VEC*DW-1:0]    in_data;
  logic [CU*VEC*DW-1:0] in_wgt;
  logic [CNTW-1:0]      cfg_terms;
  logic [SHW-1:0]       cfg_shift;
  logic                 out_valid;
  logic [CU*DW-1:0]     out_res;

  dpe_engine #(.VEC(VEC), .CU(CU), .ACCW(32), .CNTW(CNTW), .SHW(SHW)) i_dpe_engine (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_wgt(in_wgt),
    .cfg_terms(cfg_terms), .cfg_shift(cfg_shift), .out_valid(out_valid), .out_res(out_res)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  int d_mem [256][VEC];
  int w_mem [256][CU][VEC];

  task automatic chk(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic int clamp_ref(input longint s, input int sh);
    longint v;
    v = s >>> sh;
    if (v > 127) return 127;
    if (v < -128) return -128;
    return int'(v);
  endfunction

  function automatic int exp_out(input int k, input int u, input int eff, input int sh);
    longint s = 0;
    for (int i = k*eff; i < (k+1)*eff; i++)
      for (int l = 0; l < VEC; l++) s += longint'(d_mem[i][l]) * longint'(w_mem[i][u][l]);
    return clamp_ref(s, sh);
  endfunction

  // mode 0: full random, 1: all +127, 2: data -128 weights +127, 3: small values
  task automatic fill(input int mode);
    for (int i = 0; i < 256; i++)
      for (int l = 0; l < VEC; l++) begin
        case (mode)
          0: d_mem[i][l] = int'($urandom_range(255)) - 128;
          1: d_mem[i][l] = 127;
          2: d_mem[i][l] = -128;
          default: d_mem[i][l] = int'($urandom_range(15)) - 8;
        endcase
        for (int u = 0; u < CU; u++) begin
          case (mode)
            0: w_mem[i][u][l] = int'($urandom_range(255)) - 128;
            1, 2: w_mem[i][u][l] = 127;
            default: w_mem[i][u][l] = int'($urandom_range(15)) - 8;
          endcase
        end
      end
  endtask

  task automatic put_vec(input int i);
    for (int l = 0; l < VEC; l++) begin
      in_data[l*DW +: DW] = DW'(d_mem[i][l]);
      for (int u = 0; u < CU; u++) in_wgt[(u*VEC+l)*DW +: DW] = DW'(w_mem[i][u][l]);
    end
  endtask

  task automatic run_case(input string tag, input int n_out, input int terms,
                          input int sh, input bit gaps);
    int eff;
    int got;
    int extra;
    eff = (terms == 0) ? 1 : terms;
    got = 0;
    extra = 0;
    @(negedge clk);
    cfg_terms = CNTW'(terms);
    cfg_shift = SHW'(sh);
    fork
      begin
        for (int i = 0; i < n_out*eff; i++) begin
          if (gaps && (i % 2 == 1)) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_data  = VEC*DW'($urandom);
            in_wgt   = {$urandom, $urandom};
          end
          @(negedge clk);
          in_valid = 1'b1;
          put_vec(i);
        end
        @(negedge clk);
        in_valid = 1'b0;
      end
      begin
        int waitc = 0;
        while (got < n_out && waitc < 2000) begin
          @(negedge clk);
          waitc++;
          if (out_valid) begin
            // R2: each unit's own slice against the shared activations
            for (int u = 0; u < CU; u++)
              chk($sformatf("%s R2 unit%0d out%0d", tag, u, got),
                  int'($signed(out_res[u*DW +: DW])), exp_out(got, u, eff, sh));
            got++;
          end
        end
      end
    join
    repeat (10) begin
      @(negedge clk);
      if (out_valid) extra++;
    end
    // R3: one strobe per group
    chk($sformatf("%s R3 strobe count", tag), got + extra, n_out);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_data = '0;
    in_wgt = '0;
    cfg_terms = CNTW'(1);
    cfg_shift = '0;
    repeat (3) @(negedge clk);
    chk("R9 valid in reset", int'(out_valid), 0);
    chk("R9 result in reset", int'(out_res), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 valid after reset", int'(out_valid), 0);
    chk("R9 result after reset", int'(out_res), 0);
  endtask

  task automatic t_latency();
    int cnt;
    fill(3);
    @(negedge clk);
    cfg_terms = CNTW'(1);
    cfg_shift = '0;
    @(negedge clk);
    in_valid = 1'b1;
    put_vec(0);
    cnt = 0;
    do begin
      @(negedge clk);
      in_valid = 1'b0;
      cnt++;
    end while (!out_valid && cnt < 20);
    chk("R3 latency", cnt, LAT);
    for (int u = 0; u < CU; u++)
      chk($sformatf("R1 single vector unit%0d", u), int'($signed(out_res[u*DW +: DW])),
          exp_out(0, u, 1, 0));
    @(negedge clk);
    chk("R3 pulse width", int'(out_valid), 0);
    for (int u = 0; u < CU; u++)
      chk($sformatf("R3 result held unit%0d", u), int'($signed(out_res[u*DW +: DW])),
          exp_out(0, u, 1, 0));
  endtask

  initial begin : watchdog
    #1000000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_latency();
    fill(3); run_case("R1 exact sums", 3, 4, 0, 1'b0);
    fill(3); run_case("R5 restart", 5, 3, 1, 1'b0);
    fill(3); run_case("R4 idle junk", 4, 3, 0, 1'b1);
    fill(0); run_case("R7 shift", 4, 4, 10, 1'b0);
    fill(0); run_case("R7 shift odd", 3, 2, 7, 1'b1);
    fill(1); run_case("R6 upper clamp", 2, 4, 0, 1'b0);
    fill(2); run_case("R6 lower clamp", 2, 4, 0, 1'b0);
    fill(1); run_case("R7 max shift", 1, 4, 31, 1'b0);
    fill(3); run_case("R8 zero terms", 4, 0, 0, 1'b0);
    fill(3); run_case("R10 back to back", 8, 1, 0, 1'b0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule